// File: doc/BRIEF.md
# Flash Fetch Accelerator Controller

This block sits between a processor bus and a slow flash array. The flash has a programmable access time. The block keeps two line latches, one for instruction fetches and one for data reads. Each latch holds a line address tag and a valid flag. When the block is allowed to, it fetches the next sequential instruction line ahead of demand, so the flash access time is hidden from the processor.

Two word-aligned configuration registers control the block. The first selects how far the acceleration is enabled: off, partial or full. The second sets the flash access time, from 1 to 7 clocks. In the lower modes a latch hit still returns its data only after the full access time, so execution timing does not change. It costs no flash read. Any write that changes the mode empties both latches.

Requests use a simple hold-until-ready handshake, and each request returns a whole flash line. The flash port drives a line address and a read strobe. Line data must be valid by the last cycle of the strobe.

Top module: `flash_accel`

## Requirements
- R1: After reset the mode register reads 0, the timing register reads 7, and neither `req_ready` nor `fl_rd` is high.
- R2: The mode sits in bits [1:0] of the word at byte offset 0x0. The timing sits in bits [2:0] of the word at byte offset 0x4. All other bits, and all other word offsets, read as zero.
- R3: Writing 0 to the timing field stores and reads back 1.
- R4: Mode value 3 is stored and reads back as 3, but it behaves like mode 0: timed hits and no prefetch.
- R5: A request that misses its latch holds `fl_rd` high for exactly T cycles (T is the timing value) with `fl_addr` equal to the request's line address (`req_addr` without its low byte-offset bits). `req_ready` pulses for one cycle T+1 cycles after the request is first sampled, and `req_rdata` carries the flash line.
- R6: In mode 2, a data request that hits the data latch gets `req_ready` one cycle after it is sampled, with no flash read.
- R7: In modes 0 and 1, a data request that hits the data latch returns the latched line after T+1 cycles, with no flash read.
- R8: An instruction hit is served in one cycle in modes 1 and 2. In mode 0 it is timed like R7.
- R9: In modes 1 and 2, the flash read of line L+1 starts on the same clock edge that serves an instruction request for line L. In mode 0 no such read starts.
- R10: A sequential instruction request for the line being prefetched waits for that prefetch to finish and is served at its completion, which is sooner than T+1 cycles.
- R11: A request for any other line aborts the prefetch in flight. The flash address switches to the new line, and the aborted line is not latched.
- R12: A mode write that changes the stored value invalidates both latches. A write of the same value leaves them intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte address |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Read data of the addressed register |
| req_valid | input | 1 | Request held until `req_ready` |
| req_addr | input | ADDR_W | Request byte address |
| req_seq | input | 1 | Request continues the previous instruction stream |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | LINE_W | Returned line |
| fl_rd | output | 1 | Flash read strobe, high for the whole access |
| fl_addr | output | ADDR_W-log2(LINE_W/8) | Flash line address |
| fl_rdata | input | LINE_W | Flash line data |

## Verification
A stale or wrongly tagged latch shows up on the very next request for that line. The latency becomes 1 where T+1 was due, or the reverse, and the flash strobe count is wrong. A lost invalidation is caught by the first request after a mode change. A broken prefetch shows at the edge that serves an instruction: `fl_rd` and `fl_addr` there must already name the next line. A wrong abort shows within one access time, either on the flash address or as a missed hit on the following fetch.

// File: rtl/flash_accel_pkg.sv
// Shared types for the flash fetch accelerator.
// Assumes a two-bit mode field and a three-bit access-time field.
package flash_accel_pkg;
    localparam int MODE_W = 2;
    localparam int TIM_W  = 3;
    localparam logic [TIM_W-1:0] TIM_RESET = 3'd7;

    typedef enum logic [MODE_W-1:0] {
        ACC_OFF  = 2'd0,
        ACC_PART = 2'd1,
        ACC_FULL = 2'd2,
        ACC_RSVD = 2'd3
    } acc_mode_e;

    // Map the stored field to the behaviour used by the datapath.
    function automatic acc_mode_e eff_mode(input logic [MODE_W-1:0] m);
        return (m == 2'd3) ? ACC_OFF : acc_mode_e'(m);
    endfunction
endpackage

// File: rtl/flash_accel_regs.sv
// Configuration registers: the mode and the flash access time.
// Assumes word-aligned byte addresses. Bits [1:0] of the address are ignored.
module flash_accel_regs
    import flash_accel_pkg::*;
#(
    parameter int DW     = 32,
    parameter int CFG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output acc_mode_e         mode_o,
    output logic [TIM_W-1:0]  tim_o,
    output logic              mode_chg_o
);
    localparam int WIDX_W = CFG_AW - 2;

    logic [WIDX_W-1:0] word;
    logic [MODE_W-1:0] mode_q;
    logic [TIM_W-1:0]  tim_q;
    logic              wr_mode, wr_tim;
    logic              unused_bits;

    assign word        = cfg_addr[CFG_AW-1:2];
    assign wr_mode     = cfg_we && (word == WIDX_W'(0));
    assign wr_tim      = cfg_we && (word == WIDX_W'(1));
    assign mode_chg_o  = wr_mode && (cfg_wdata[MODE_W-1:0] != mode_q);
    assign mode_o      = eff_mode(mode_q);
    assign tim_o       = tim_q;
    assign unused_bits = ^{cfg_addr[1:0], cfg_wdata[DW-1:TIM_W]};

    // Store register writes; a zero access time is raised to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tim_q  <= TIM_RESET;
        end else begin
            if (wr_mode) mode_q <= cfg_wdata[MODE_W-1:0];
            if (wr_tim)  tim_q  <= (cfg_wdata[TIM_W-1:0] == '0) ? TIM_W'(1) : cfg_wdata[TIM_W-1:0];
        end
    end

    // Return the addressed register, with unused bits read as zero.
    always_comb begin
        cfg_rdata = '0;
        if (word == WIDX_W'(0))      cfg_rdata = {{(DW-MODE_W){1'b0}}, mode_q};
        else if (word == WIDX_W'(1)) cfg_rdata = {{(DW-TIM_W){1'b0}}, tim_q};
    end

    p_tim_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tim && cfg_wdata[TIM_W-1:0] == '0) |=> (tim_q == TIM_W'(1)));
    p_mode_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (mode_q == $past(cfg_wdata[MODE_W-1:0])));
endmodule

// File: rtl/flash_accel_latch.sv
// One line holding latch with a tag and a valid flag.
// A fill takes priority over a flush, so freshly read data survives.
module flash_accel_latch #(
    parameter int TAG_W  = 12,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_data,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [LINE_W-1:0] data_o
);
    // Track the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_o <= 1'b0;
        else if (fill)  valid_o <= 1'b1;
        else if (flush) valid_o <= 1'b0;
    end

    // Capture the tag and the line on a fill.
    always_ff @(posedge clk) begin
        if (fill) begin
            tag_o  <= fill_tag;
            data_o <= fill_data;
        end
    end
endmodule

// File: rtl/flash_accel_engine.sv
// Request and prefetch engine. It runs one flash access or one timed
// hit at a time, prefetches the next instruction line, and lets a
// sequential request join a prefetch already in flight.
// Assumes the requester holds req_valid until req_ready.
module flash_accel_engine
    import flash_accel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 128,
    parameter int OFF_W  = 4,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_mode_e         mode_i,
    input  logic [TIM_W-1:0]  tim_i,
    input  logic              mode_chg_i,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    input  logic              req_instr,
    output logic              req_ready,
    output logic [LINE_W-1:0] req_rdata,
    output logic              fl_rd,
    output logic [TAG_W-1:0]  fl_addr,
    input  logic [LINE_W-1:0] fl_rdata,
    input  logic              i_valid,
    input  logic [TAG_W-1:0]  i_tag,
    input  logic [LINE_W-1:0] i_data,
    input  logic              d_valid,
    input  logic [TAG_W-1:0]  d_tag,
    input  logic [LINE_W-1:0] d_data,
    output logic              fill_i_o,
    output logic              fill_d_o,
    output logic [TAG_W-1:0]  fill_tag_o,
    output logic [LINE_W-1:0] fill_data_o
);
    logic              busy_q, wait_q, isfl_q, dsti_q, rdy_q;
    logic [TAG_W-1:0]  line_q;
    logic [TIM_W-1:0]  cnt_q;
    logic [LINE_W-1:0] rdata_q;

    logic              n_busy, n_wait, n_isfl, n_dsti, n_rdy, pf_go;
    logic [TAG_W-1:0]  n_line, pf_line, rline;
    logic [TIM_W-1:0]  n_cnt;
    logic [LINE_W-1:0] n_rdata, hit_data;
    logic              pf_en, hit, fast, accept, join_pf, done;
    logic              unused_off;

    assign rline      = req_addr[ADDR_W-1:OFF_W];
    assign unused_off = ^req_addr[OFF_W-1:0];
    assign pf_en      = (mode_i != ACC_OFF);
    assign hit        = req_instr ? (i_valid && i_tag == rline) : (d_valid && d_tag == rline);
    assign hit_data   = req_instr ? i_data : d_data;
    assign fast       = hit && (req_instr ? pf_en : (mode_i == ACC_FULL));
    assign accept     = req_valid && !rdy_q && !wait_q;
    assign join_pf    = busy_q && req_instr && req_seq && (line_q == rline);
    assign done       = busy_q && (cnt_q == TIM_W'(1));

    assign fl_rd       = busy_q && isfl_q;
    assign fl_addr     = line_q;
    assign fill_tag_o  = line_q;
    assign fill_data_o = fl_rdata;
    assign fill_i_o    = done && isfl_q && dsti_q && !(mode_chg_i && !wait_q);
    assign fill_d_o    = done && isfl_q && !dsti_q;
    assign req_ready   = rdy_q;
    assign req_rdata   = rdata_q;

    // Next-state selection: completion, new request, prefetch launch, kill.
    always_comb begin
        n_busy  = busy_q;
        n_wait  = wait_q;
        n_isfl  = isfl_q;
        n_dsti  = dsti_q;
        n_line  = line_q;
        n_cnt   = (busy_q && !done) ? cnt_q - TIM_W'(1) : cnt_q;
        n_rdy   = 1'b0;
        n_rdata = rdata_q;
        pf_go   = 1'b0;
        pf_line = line_q + TAG_W'(1);
        if (done) begin
            n_busy = 1'b0;
            if (wait_q) begin
                n_rdy  = 1'b1;
                n_wait = 1'b0;
                if (isfl_q) n_rdata = fl_rdata;
                pf_go  = dsti_q && pf_en;
            end
        end
        if (accept) begin
            if (join_pf) begin
                if (done) begin
                    n_rdy   = 1'b1;
                    n_rdata = fl_rdata;
                    pf_go   = pf_en;
                end else begin
                    n_wait = 1'b1;
                end
            end else if (fast) begin
                n_busy  = 1'b0;
                n_rdy   = 1'b1;
                n_rdata = hit_data;
                pf_go   = req_instr && pf_en;
                pf_line = rline + TAG_W'(1);
            end else begin
                n_busy  = 1'b1;
                n_wait  = 1'b1;
                n_isfl  = !hit;
                n_dsti  = req_instr;
                n_line  = rline;
                n_cnt   = tim_i;
                n_rdata = hit_data;
            end
        end
        if (pf_go) begin
            n_busy = 1'b1;
            n_wait = 1'b0;
            n_isfl = 1'b1;
            n_dsti = 1'b1;
            n_line = pf_line;
            n_cnt  = tim_i;
        end
        if (mode_chg_i && !n_wait) n_busy = 1'b0;
    end

    // Register the engine state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wait_q  <= 1'b0;
            isfl_q  <= 1'b0;
            dsti_q  <= 1'b0;
            rdy_q   <= 1'b0;
            line_q  <= '0;
            cnt_q   <= TIM_W'(1);
            rdata_q <= '0;
        end else begin
            busy_q  <= n_busy;
            wait_q  <= n_wait;
            isfl_q  <= n_isfl;
            dsti_q  <= n_dsti;
            rdy_q   <= n_rdy;
            line_q  <= n_line;
            cnt_q   <= n_cnt;
            rdata_q <= n_rdata;
        end
    end

    p_rdy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0));
    p_fast_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !join_pf && fast && !req_instr) |=> req_ready);
    p_pf_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !join_pf && fast && req_instr && pf_en && !mode_chg_i)
        |=> (fl_rd && fl_addr == $past(rline) + TAG_W'(1)));
endmodule

// File: rtl/flash_accel.sv
// Top of the flash fetch accelerator: registers, two line latches
// (index 0 data, index 1 instruction) and the request engine.
// Assumes the flash returns a stable line for the address it is given.
module flash_accel
    import flash_accel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 128,
    parameter int CFG_AW = 4,
    parameter int DW     = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cfg_we,
    input  logic [CFG_AW-1:0]                       cfg_addr,
    input  logic [DW-1:0]                           cfg_wdata,
    output logic [DW-1:0]                           cfg_rdata,
    input  logic                                    req_valid,
    input  logic [ADDR_W-1:0]                       req_addr,
    input  logic                                    req_seq,
    input  logic                                    req_instr,
    output logic                                    req_ready,
    output logic [LINE_W-1:0]                       req_rdata,
    output logic                                    fl_rd,
    output logic [ADDR_W-$clog2(LINE_W/8)-1:0]      fl_addr,
    input  logic [LINE_W-1:0]                       fl_rdata
);
    localparam int OFF_W = $clog2(LINE_W/8);
    localparam int TAG_W = ADDR_W - OFF_W;

    acc_mode_e         mode;
    logic [TIM_W-1:0]  tim;
    logic              mode_chg;
    logic [1:0]        lv, lfill;
    logic [TAG_W-1:0]  lt [2];
    logic [LINE_W-1:0] ld [2];
    logic              fill_i, fill_d;
    logic [TAG_W-1:0]  fill_tag;
    logic [LINE_W-1:0] fill_data;

    flash_accel_regs #(.DW(DW), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_o(mode),
        .tim_o(tim), .mode_chg_o(mode_chg)
    );

    assign lfill = {fill_i, fill_d};

    for (genvar g = 0; g < 2; g++) begin : g_latch
        flash_accel_latch #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_latch (
            .clk(clk), .rst_n(rst_n), .flush(mode_chg), .fill(lfill[g]),
            .fill_tag(fill_tag), .fill_data(fill_data),
            .valid_o(lv[g]), .tag_o(lt[g]), .data_o(ld[g])
        );
    end

    flash_accel_engine #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .tim_i(tim), .mode_chg_i(mode_chg),
        .req_valid(req_valid), .req_addr(req_addr), .req_seq(req_seq), .req_instr(req_instr),
        .req_ready(req_ready), .req_rdata(req_rdata), .fl_rd(fl_rd), .fl_addr(fl_addr),
        .fl_rdata(fl_rdata), .i_valid(lv[1]), .i_tag(lt[1]), .i_data(ld[1]),
        .d_valid(lv[0]), .d_tag(lt[0]), .d_data(ld[0]), .fill_i_o(fill_i),
        .fill_d_o(fill_d), .fill_tag_o(fill_tag), .fill_data_o(fill_data)
    );

    p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !fill_i && !fill_d) |=> (lv == 2'b00));
endmodule

// File: tb/flash_accel_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// checked against a small latch model.
module flash_accel_bench;
    localparam int ADDR_W = 16;
    localparam int LINE_W = 128;
    localparam int OFF_W  = 4;
    localparam int TAG_W  = ADDR_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_seq = 1'b0;
    logic              req_instr = 1'b0;
    logic              req_ready;
    logic [LINE_W-1:0] req_rdata;
    logic              fl_rd;
    logic [TAG_W-1:0]  fl_addr;
    logic [LINE_W-1:0] fl_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    function automatic logic [LINE_W-1:0] fdata(input logic [TAG_W-1:0] ln);
        logic [31:0] x;
        x = {20'h0, ln};
        return {x * 32'h9E3779B1, ~x, x ^ 32'h5A5A0000, x + 32'h100};
    endfunction

    assign fl_rdata = fdata(fl_addr);

    flash_accel u_flash_accel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_seq(req_seq), .req_instr(req_instr),
        .req_ready(req_ready), .req_rdata(req_rdata), .fl_rd(fl_rd),
        .fl_addr(fl_addr), .fl_rdata(fl_rdata)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Issue one request; report cycles to ready, flash strobe cycles,
    // the returned line and the first flash address seen.
    task automatic run_req(input logic [TAG_W-1:0] ln, input bit ins, input bit sq,
                           output int lat, output int flc,
                           output logic [LINE_W-1:0] dat, output logic [TAG_W-1:0] fa0);
        bit got = 0;
        @(negedge clk);
        req_valid = 1'b1; req_instr = ins; req_seq = sq;
        req_addr = {ln, OFF_W'($urandom)};
        lat = 0; flc = 0; dat = '0; fa0 = '1;
        while (lat < 40 && !got) begin
            @(negedge clk);
            lat++;
            if (req_ready) begin
                got = 1; dat = req_rdata;
            end else if (fl_rd) begin
                if (flc == 0) fa0 = fl_addr;
                flc++;
            end
        end
        req_valid = 1'b0;
        if (!got) chk(0, "R5", "request never completed", 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat, flc;
        logic [LINE_W-1:0] dat;
        logic [TAG_W-1:0] fa0;
        logic [31:0] rd;
        logic [1:0] m_mode;
        logic [2:0] m_tim;
        bit iv, dv;
        logic [TAG_W-1:0] itag, dtag;

        void'($urandom(32'd4711));
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(req_ready == 0, "R1", "ready after reset", req_ready, 0);
        chk(fl_rd == 0, "R1", "flash read after reset", fl_rd, 0);
        cfg_rd(4'h0, rd); chk(rd == 0, "R1", "mode reset", rd, 0);
        cfg_rd(4'h4, rd); chk(rd == 7, "R1", "timing reset", rd, 7);

        // R2: field positions and unused bits
        cfg_wr(4'h0, 32'hFFFF_FFF2);
        cfg_rd(4'h0, rd); chk(rd == 2, "R2", "mode word", rd, 2);
        cfg_wr(4'h4, 32'hFFFF_FFF3);
        cfg_rd(4'h4, rd); chk(rd == 3, "R2", "timing word", rd, 3);
        cfg_rd(4'h8, rd); chk(rd == 0, "R2", "unused word", rd, 0);

        // R3: zero timing stored as one
        cfg_wr(4'h4, 32'h0);
        cfg_rd(4'h4, rd); chk(rd == 1, "R3", "timing zero", rd, 1);
        cfg_wr(4'h4, 32'h3);

        // R5 miss then R6 fast data hit (mode 2, T=3)
        run_req(12'd5, 0, 0, lat, flc, dat, fa0);
        chk(lat == 4, "R5", "miss latency", lat, 4);
        chk(flc == 3, "R5", "miss strobe cycles", flc, 3);
        chk(fa0 == 5, "R5", "miss flash address", fa0, 5);
        chk(dat == fdata(12'd5), "R5", "miss data", dat, fdata(12'd5));
        run_req(12'd5, 0, 1, lat, flc, dat, fa0);
        chk(lat == 1 && flc == 0, "R6", "fast data hit", lat, 1);
        chk(dat == fdata(12'd5), "R6", "hit data", dat, fdata(12'd5));

        // R12 flush on change, R7 timed hit in mode 1
        cfg_wr(4'h0, 32'h1);
        run_req(12'd5, 0, 0, lat, flc, dat, fa0);
        chk(lat == 4 && flc == 3, "R12", "miss after mode change", flc, 3);
        run_req(12'd5, 0, 0, lat, flc, dat, fa0);
        chk(lat == 4, "R7", "timed hit latency", lat, 4);
        chk(flc == 0, "R7", "timed hit strobe", flc, 0);
        chk(dat == fdata(12'd5), "R7", "timed hit data", dat, fdata(12'd5));
        cfg_wr(4'h0, 32'h1);
        run_req(12'd5, 0, 0, lat, flc, dat, fa0);
        chk(flc == 0, "R12", "same-mode write keeps latch", flc, 0);

        // R9 prefetch start, R8 fast instruction hit (mode 1)
        run_req(12'd10, 1, 0, lat, flc, dat, fa0);
        chk(lat == 4, "R5", "instr miss latency", lat, 4);
        chk(fl_rd == 1 && fl_addr == 11, "R9", "prefetch launch", fl_addr, 11);
        idle(9);
        run_req(12'd11, 1, 1, lat, flc, dat, fa0);
        chk(lat == 1 && flc == 0, "R8", "instr hit mode 1", lat, 1);
        chk(dat == fdata(12'd11), "R8", "prefetched data", dat, fdata(12'd11));
        idle(9);

        // Mode 0: no prefetch (R9), timed instruction hit (R8)
        cfg_wr(4'h0, 32'h0);
        run_req(12'd20, 1, 0, lat, flc, dat, fa0);
        chk(fl_rd == 0, "R9", "no prefetch in mode 0", fl_rd, 0);
        run_req(12'd20, 1, 1, lat, flc, dat, fa0);
        chk(lat == 4 && flc == 0, "R8", "timed instr hit mode 0", lat, 4);

        // R4: reserved mode value
        cfg_wr(4'h0, 32'h3);
        cfg_rd(4'h0, rd); chk(rd == 3, "R4", "mode 3 stored", rd, 3);
        run_req(12'd7, 0, 0, lat, flc, dat, fa0);
        run_req(12'd7, 0, 0, lat, flc, dat, fa0);
        chk(lat == 4 && flc == 0, "R4", "mode 3 timed hit", lat, 4);
        run_req(12'd30, 1, 0, lat, flc, dat, fa0);
        chk(fl_rd == 0, "R4", "mode 3 no prefetch", fl_rd, 0);

        // R10: join a prefetch in flight (mode 2, T=5)
        idle(9);
        cfg_wr(4'h0, 32'h2);
        cfg_wr(4'h4, 32'h5);
        run_req(12'd40, 1, 0, lat, flc, dat, fa0);
        chk(lat == 6, "R5", "miss latency T=5", lat, 6);
        run_req(12'd41, 1, 1, lat, flc, dat, fa0);
        chk(lat == 4, "R10", "join latency", lat, 4);
        chk(dat == fdata(12'd41), "R10", "join data", dat, fdata(12'd41));

        // R11: abort the prefetch for another line
        idle(9);
        run_req(12'd50, 1, 0, lat, flc, dat, fa0);
        run_req(12'd60, 0, 0, lat, flc, dat, fa0);
        chk(fa0 == 60, "R11", "flash address after abort", fa0, 60);
        chk(lat == 6, "R11", "aborting request latency", lat, 6);
        idle(9);
        run_req(12'd51, 1, 1, lat, flc, dat, fa0);
        chk(lat == 6 && flc == 5, "R11", "aborted line not latched", lat, 6);

        // Random phase against a latch model
        idle(9);
        cfg_wr(4'h0, 32'h1);
        m_mode = 2'd1; m_tim = 3'd5; iv = 0; dv = 0; itag = '0; dtag = '0;
        for (int k = 0; k < 300; k++) begin
            int r;
            idle(9);
            r = int'($urandom % 10);
            if (r == 0) begin
                logic [1:0] nm;
                nm = 2'($urandom);
                cfg_wr(4'h0, {30'h0, nm});
                if (nm != m_mode) begin iv = 0; dv = 0; end
                m_mode = nm;
            end else if (r == 1) begin
                logic [2:0] nt;
                nt = 3'($urandom);
                cfg_wr(4'h4, {29'h0, nt});
                m_tim = (nt == 0) ? 3'd1 : nt;
            end else begin
                logic [TAG_W-1:0] ln;
                bit ins, h, f;
                logic [1:0] em;
                string tag;
                ln  = TAG_W'($urandom % 6);
                ins = 1'($urandom);
                em  = (m_mode == 3) ? 2'd0 : m_mode;
                h   = ins ? (iv && itag == ln) : (dv && dtag == ln);
                f   = h && (ins ? (em != 0) : (em == 2));
                tag = !h ? "R5" : (ins ? "R8" : (f ? "R6" : "R7"));
                run_req(ln, ins, 1'($urandom), lat, flc, dat, fa0);
                chk(lat == (f ? 1 : int'(m_tim) + 1), tag, "random latency", lat, f ? 1 : int'(m_tim) + 1);
                chk(flc == (h ? 0 : int'(m_tim)), tag, "random strobe cycles", flc, h ? 0 : int'(m_tim));
                chk(dat == fdata(ln), tag, "random data", dat, fdata(ln));
                if (!h && ins)  begin iv = 1; itag = ln; end
                if (!h && !ins) begin dv = 1; dtag = ln; end
                if (ins && em != 0) begin iv = 1; itag = ln + TAG_W'(1); end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule